// File: doc/BRIEF.md
# Convolution Layer Pixel Sequencer

This block is the control engine that steps one convolution layer across a feature map. The layer shape is taken from configuration inputs: height, width, input channel count, output channel count, a stride-2 select and a global-pool enable. These values are latched when a start pulse arrives. After that the block sends an ordered stream of commands to four peers: an image-cache loader, a processing element, a post-processor and a writeback unit. The arithmetic and the memory traffic stay inside those peers. This block decides only what happens and in which order.

Before the scan, the image cache is primed with all of row 0 and with the pixel at row 1, column 0. The scan then visits every position, row by row. At each position it first asks for the next pixel of the map. With stride 2, a position whose column or row is odd is dropped after that request. At every other position the block runs all input channels through the processing element. It then hands the output coordinate to the writeback unit. Finally it walks the output channels, and for each one it issues a postprocess request followed by a writeback.

Top module: `conv_pixel_sequencer`

## Requirements
- R1: After start, the first loader command is a row preload (ld_kind=0) of row 0. If height > 1, the second is a pixel preload (ld_kind=1) of row 1, column 0.
- R2: Positions are visited with the row as the outer loop and the column as the inner loop. Each position begins with one pixel preload of the next not-yet-loaded pixel in row-major order, while such a pixel exists.
- R3: Pixel preloads stop when the map is exhausted. One layer issues exactly 1 + height*width - width loader commands.
- R4: With cfg_stride2=1, a position with an odd row or odd column gets no processing, postprocess or writeback command.
- R5: At each kept position, one processing command is issued for each input channel, with indices 0 to ch_in-1 in ascending order. All of them come before any writeback command for that position.
- R6: After the input channels, a writeback setup command (wb_op=0) carries the output coordinate. This equals the position for stride 1, and the position halved (rounded down) for stride 2.
- R7: Next, for each output channel co in ascending order, a postprocess command carries co and a bias index equal to the input channel count. It is followed by a writeback command (wb_op=1) for co.
- R8: With global pool enabled, each writeback command carries wb_gp=1 (set) at output coordinate (0,0) and wb_gp=2 (accumulate) elsewhere. With global pool disabled it carries wb_gp=0.
- R9: At most one command port is valid at a time. A valid command holds its fields unchanged until the peer accepts it.
- R10: done pulses for exactly one cycle when the scan ends, and busy is low from that cycle on. A start pulse while busy is ignored, along with any configuration change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_height | input | DIM_W | Map height in pixels |
| cfg_width | input | DIM_W | Map width in pixels |
| cfg_ch_in | input | CH_W | Input channel count |
| cfg_ch_out | input | CH_W | Output channel count |
| cfg_stride2 | input | 1 | 1 selects stride 2 |
| cfg_gpool | input | 1 | Global-pool enable |
| start | input | 1 | Start pulse, sampled while idle |
| busy | output | 1 | Layer in progress |
| done | output | 1 | One-cycle end-of-layer pulse |
| ld_valid | output | 1 | Loader command valid |
| ld_ready | input | 1 | Loader accepts |
| ld_kind | output | 1 | 0 = row preload, 1 = pixel preload |
| ld_row | output | DIM_W | Row to load |
| ld_col | output | DIM_W | Column of pixel to load |
| pe_valid | output | 1 | Processing command valid |
| pe_ready | input | 1 | Processing element accepts |
| pe_y | output | DIM_W | Position row |
| pe_x | output | DIM_W | Position column |
| pe_ci | output | CH_W | Input channel index |
| pp_valid | output | 1 | Postprocess command valid |
| pp_ready | input | 1 | Post-processor accepts |
| pp_co | output | CH_W | Output channel |
| pp_bias_ci | output | CH_W | Input-channel index used for bias selection |
| wb_valid | output | 1 | Writeback command valid |
| wb_ready | input | 1 | Writeback unit accepts |
| wb_op | output | 1 | 0 = coordinate setup, 1 = channel write |
| wb_y | output | DIM_W | Output row |
| wb_x | output | DIM_W | Output column |
| wb_co | output | CH_W | Output channel being written |
| wb_gp | output | 2 | Global pool: 0 none, 1 set, 2 accumulate |

## Verification
A command is valid on the cycle after the state that owns it is entered. It is accepted on the first rising edge where its ready is high, and the following command appears one edge later. Because the latency is variable, the bench does not predict absolute cycles. It drives each ready at random just after the falling edge and samples 1 ns later. It logs a command exactly when valid and ready are both high, since that handshake is what the next rising edge takes. The logged stream is compared in order against a stream built from the requirements. done is counted over the whole run, and after the done pulse the bench waits a few cycles before checking busy and confirming that no second pulse appeared.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ROW, ST_PIX0, ST_POS, ST_PE, ST_WSET, ST_PP, ST_WB, ST_ADV
  } seq_state_e;

  localparam logic       LD_ROW   = 1'b0;
  localparam logic       LD_PIXEL = 1'b1;
  localparam logic       WB_SETUP = 1'b0;
  localparam logic       WB_WRITE = 1'b1;
  localparam logic [1:0] GP_NONE  = 2'd0;
  localparam logic [1:0] GP_SET   = 2'd1;
  localparam logic [1:0] GP_ACC   = 2'd2;
endpackage

// File: rtl/conv_seq_scan.sv
// Raster position counter: column inner, row outer.
module conv_seq_scan #(
  parameter int DIM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             adv,
  input  logic [DIM_W-1:0] height,
  input  logic [DIM_W-1:0] width,
  output logic [DIM_W-1:0] y,
  output logic [DIM_W-1:0] x,
  output logic             last
);
  always_ff @(posedge clk) begin
    if (rst || init) begin
      y <= '0;
      x <= '0;
    end else if (adv) begin
      if (x == width - DIM_W'(1)) begin
        x <= '0;
        y <= y + DIM_W'(1);
      end else begin
        x <= x + DIM_W'(1);
      end
    end
  end

  assign last = (y == height - DIM_W'(1)) && (x == width - DIM_W'(1));
endmodule

// File: rtl/conv_seq_load_ptr.sv
// Pointer to the next pixel the image cache has not yet received.
module conv_seq_load_ptr #(
  parameter int DIM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             adv,
  input  logic [DIM_W-1:0] height,
  input  logic [DIM_W-1:0] width,
  output logic [DIM_W-1:0] row,
  output logic [DIM_W-1:0] col,
  output logic             in_map
);
  always_ff @(posedge clk) begin
    if (rst) begin
      row <= '0;
      col <= '0;
    end else if (init) begin
      row <= DIM_W'(1);
      col <= '0;
    end else if (adv) begin
      if (col == width - DIM_W'(1)) begin
        col <= '0;
        row <= row + DIM_W'(1);
      end else begin
        col <= col + DIM_W'(1);
      end
    end
  end

  assign in_map = row < height;
endmodule

// File: rtl/conv_pixel_sequencer.sv
module conv_pixel_sequencer
  import conv_seq_pkg::*;
#(
  parameter int DIM_W = 8,
  parameter int CH_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIM_W-1:0] cfg_height,
  input  logic [DIM_W-1:0] cfg_width,
  input  logic [CH_W-1:0]  cfg_ch_in,
  input  logic [CH_W-1:0]  cfg_ch_out,
  input  logic             cfg_stride2,
  input  logic             cfg_gpool,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             ld_valid,
  input  logic             ld_ready,
  output logic             ld_kind,
  output logic [DIM_W-1:0] ld_row,
  output logic [DIM_W-1:0] ld_col,
  output logic             pe_valid,
  input  logic             pe_ready,
  output logic [DIM_W-1:0] pe_y,
  output logic [DIM_W-1:0] pe_x,
  output logic [CH_W-1:0]  pe_ci,
  output logic             pp_valid,
  input  logic             pp_ready,
  output logic [CH_W-1:0]  pp_co,
  output logic [CH_W-1:0]  pp_bias_ci,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic             wb_op,
  output logic [DIM_W-1:0] wb_y,
  output logic [DIM_W-1:0] wb_x,
  output logic [CH_W-1:0]  wb_co,
  output logic [1:0]       wb_gp
);
  seq_state_e       state;
  logic [DIM_W-1:0] h_q, w_q;
  logic [CH_W-1:0]  ch_in_q, ch_out_q, ci_q, co_q;
  logic             stride2_q, gpool_q, done_q;

  logic [DIM_W-1:0] sy, sx, lrow, lcol, yo, xo;
  logic             slast, lin, launch, skip;
  logic             ld_fire, pe_fire, pp_fire, wb_fire;

  assign launch = (state == ST_IDLE) && start;

  conv_seq_scan #(.DIM_W(DIM_W)) u_scan (
    .clk(clk), .rst(rst), .init(launch),
    .adv((state == ST_ADV) && !slast),
    .height(h_q), .width(w_q), .y(sy), .x(sx), .last(slast)
  );

  conv_seq_load_ptr #(.DIM_W(DIM_W)) u_lptr (
    .clk(clk), .rst(rst), .init(launch),
    .adv(ld_fire && (state != ST_ROW)),
    .height(h_q), .width(w_q), .row(lrow), .col(lcol), .in_map(lin)
  );

  // Command ports, driven from registered state and counters
  assign ld_valid = (state == ST_ROW) || (((state == ST_PIX0) || (state == ST_POS)) && lin);
  assign ld_kind  = (state == ST_ROW) ? LD_ROW : LD_PIXEL;
  assign ld_row   = (state == ST_ROW) ? '0 : lrow;
  assign ld_col   = (state == ST_ROW) ? '0 : lcol;

  assign pe_valid = (state == ST_PE);
  assign pe_y     = sy;
  assign pe_x     = sx;
  assign pe_ci    = ci_q;

  assign pp_valid   = (state == ST_PP);
  assign pp_co      = co_q;
  assign pp_bias_ci = ch_in_q;

  assign yo       = stride2_q ? {1'b0, sy[DIM_W-1:1]} : sy;
  assign xo       = stride2_q ? {1'b0, sx[DIM_W-1:1]} : sx;
  assign wb_valid = (state == ST_WSET) || (state == ST_WB);
  assign wb_op    = (state == ST_WB) ? WB_WRITE : WB_SETUP;
  assign wb_y     = yo;
  assign wb_x     = xo;
  assign wb_co    = co_q;
  assign wb_gp    = !gpool_q ? GP_NONE :
                    ((yo == '0) && (xo == '0)) ? GP_SET : GP_ACC;

  assign ld_fire = ld_valid && ld_ready;
  assign pe_fire = pe_valid && pe_ready;
  assign pp_fire = pp_valid && pp_ready;
  assign wb_fire = wb_valid && wb_ready;

  assign skip = stride2_q && (sx[0] || sy[0]);
  assign busy = (state != ST_IDLE);
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done_q    <= 1'b0;
      h_q       <= '0;
      w_q       <= '0;
      ch_in_q   <= '0;
      ch_out_q  <= '0;
      stride2_q <= 1'b0;
      gpool_q   <= 1'b0;
      ci_q      <= '0;
      co_q      <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          h_q       <= cfg_height;
          w_q       <= cfg_width;
          ch_in_q   <= cfg_ch_in;
          ch_out_q  <= cfg_ch_out;
          stride2_q <= cfg_stride2;
          gpool_q   <= cfg_gpool;
          state     <= ST_ROW;
        end
        ST_ROW:  if (ld_fire) state <= ST_PIX0;
        ST_PIX0: if (!lin || ld_fire) state <= ST_POS;
        ST_POS:  if (!lin || ld_fire) begin
          if (skip) state <= ST_ADV;
          else begin
            ci_q  <= '0;
            state <= ST_PE;
          end
        end
        ST_PE: if (pe_fire) begin
          if (ci_q == ch_in_q - CH_W'(1)) state <= ST_WSET;
          else ci_q <= ci_q + CH_W'(1);
        end
        ST_WSET: if (wb_fire) begin
          co_q  <= '0;
          state <= ST_PP;
        end
        ST_PP: if (pp_fire) state <= ST_WB;
        ST_WB: if (wb_fire) begin
          if (co_q == ch_out_q - CH_W'(1)) state <= ST_ADV;
          else begin
            co_q  <= co_q + CH_W'(1);
            state <= ST_PP;
          end
        end
        ST_ADV: begin
          if (slast) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            state <= ST_POS;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/conv_seq_checker.sv
module conv_seq_checker #(
  parameter int DIM_W = 8,
  parameter int CH_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             ld_valid,
  input logic             ld_ready,
  input logic             ld_kind,
  input logic [DIM_W-1:0] ld_row,
  input logic [DIM_W-1:0] ld_col,
  input logic             pe_valid,
  input logic             pe_ready,
  input logic [DIM_W-1:0] pe_y,
  input logic [DIM_W-1:0] pe_x,
  input logic [CH_W-1:0]  pe_ci,
  input logic             pp_valid,
  input logic [CH_W-1:0]  pp_bias_ci,
  input logic             wb_valid,
  input logic             wb_ready,
  input logic             wb_op,
  input logic [DIM_W-1:0] wb_y,
  input logic [DIM_W-1:0] wb_x,
  input logic [CH_W-1:0]  wb_co,
  input logic [1:0]       wb_gp,
  input logic [CH_W-1:0]  ch_in_q,
  input logic             stride2_q
);
  p_one_port_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_valid, pe_valid, pp_valid, wb_valid}));

  p_ld_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ld_valid && !ld_ready |=> ld_valid && $stable(ld_kind) && $stable(ld_row) && $stable(ld_col));

  p_pe_hold_r9: assert property (@(posedge clk) disable iff (rst)
    pe_valid && !pe_ready |=> pe_valid && $stable(pe_ci) && $stable(pe_y) && $stable(pe_x));

  p_wb_hold_r9: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_op) && $stable(wb_co) && $stable(wb_y));

  p_stride_skip_r4: assert property (@(posedge clk) disable iff (rst)
    pe_valid && stride2_q |-> !(pe_x[0] || pe_y[0]));

  p_ci_range_r5: assert property (@(posedge clk) disable iff (rst)
    pe_valid |-> pe_ci < ch_in_q);

  p_bias_index_r7: assert property (@(posedge clk) disable iff (rst)
    pp_valid |-> pp_bias_ci == ch_in_q);

  p_gp_origin_r8: assert property (@(posedge clk) disable iff (rst)
    wb_valid && wb_op && (wb_gp == 2'd1) |-> (wb_y == '0) && (wb_x == '0));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(ch_in_q) && $stable(stride2_q));
endmodule

bind conv_pixel_sequencer conv_seq_checker #(.DIM_W(DIM_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_kind(ld_kind), .ld_row(ld_row), .ld_col(ld_col),
  .pe_valid(pe_valid), .pe_ready(pe_ready), .pe_y(pe_y), .pe_x(pe_x), .pe_ci(pe_ci),
  .pp_valid(pp_valid), .pp_bias_ci(pp_bias_ci),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_op(wb_op), .wb_y(wb_y), .wb_x(wb_x),
  .wb_co(wb_co), .wb_gp(wb_gp), .ch_in_q(ch_in_q), .stride2_q(stride2_q)
);

// File: tb/tb_conv_pixel_sequencer.sv
`timescale 1ns/1ps
module tb_conv_pixel_sequencer;
  localparam int DIM_W = 8;
  localparam int CH_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [DIM_W-1:0] cfg_height = '0, cfg_width = '0;
  logic [CH_W-1:0]  cfg_ch_in = '0, cfg_ch_out = '0;
  logic cfg_stride2 = 1'b0, cfg_gpool = 1'b0, start = 1'b0;
  logic busy, done, ld_valid, ld_kind, pe_valid, pp_valid, wb_valid, wb_op;
  logic ld_ready = 1'b0, pe_ready = 1'b0, pp_ready = 1'b0, wb_ready = 1'b0;
  logic [DIM_W-1:0] ld_row, ld_col, pe_y, pe_x, wb_y, wb_x;
  logic [CH_W-1:0]  pe_ci, pp_co, pp_bias_ci, wb_co;
  logic [1:0]       wb_gp;

  conv_pixel_sequencer #(.DIM_W(DIM_W), .CH_W(CH_W)) dut (
    .clk(clk), .rst(rst), .cfg_height(cfg_height), .cfg_width(cfg_width),
    .cfg_ch_in(cfg_ch_in), .cfg_ch_out(cfg_ch_out), .cfg_stride2(cfg_stride2),
    .cfg_gpool(cfg_gpool), .start(start), .busy(busy), .done(done),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_kind(ld_kind), .ld_row(ld_row), .ld_col(ld_col),
    .pe_valid(pe_valid), .pe_ready(pe_ready), .pe_y(pe_y), .pe_x(pe_x), .pe_ci(pe_ci),
    .pp_valid(pp_valid), .pp_ready(pp_ready), .pp_co(pp_co), .pp_bias_ci(pp_bias_ci),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_op(wb_op), .wb_y(wb_y), .wb_x(wb_x),
    .wb_co(wb_co), .wb_gp(wb_gp)
  );

  int checks = 0, failures = 0;
  int done_cnt = 0, hold_errs = 0;
  logic [31:0] exp_q[$];
  logic [31:0] act_q[$];

  function automatic logic [31:0] ev(int t, int a, int b, int c, int d);
    return {t[3:0], a[7:0], b[7:0], c[7:0], d[3:0]};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Peer model and monitor: ready changes after the falling edge, then
  // the handshake the next rising edge will take is recorded.
  logic pend_ld = 0, pend_pe = 0, pend_wb = 0;
  logic [31:0] hold_ld, hold_pe, hold_wb;
  initial begin
    void'($urandom(32'd7321));
    forever begin
      @(negedge clk);
      ld_ready = ($urandom % 4) != 0;
      pe_ready = ($urandom % 4) != 0;
      pp_ready = ($urandom % 4) != 0;
      wb_ready = ($urandom % 3) != 0;
      #1;
      if (!rst) begin
        if (done) done_cnt++;
        if (pend_ld && !(ld_valid && ev(1, ld_kind, ld_row, ld_col, 0) == hold_ld)) hold_errs++;
        if (pend_pe && !(pe_valid && ev(2, pe_y, pe_x, pe_ci, 0) == hold_pe)) hold_errs++;
        if (pend_wb && !(wb_valid && ev(3, wb_op, wb_y, wb_x, wb_co) == hold_wb)) hold_errs++;
        if (int'(ld_valid) + int'(pe_valid) + int'(pp_valid) + int'(wb_valid) > 1) hold_errs++;
        pend_ld = ld_valid && !ld_ready; hold_ld = ev(1, ld_kind, ld_row, ld_col, 0);
        pend_pe = pe_valid && !pe_ready; hold_pe = ev(2, pe_y, pe_x, pe_ci, 0);
        pend_wb = wb_valid && !wb_ready; hold_wb = ev(3, wb_op, wb_y, wb_x, wb_co);
        if (ld_valid && ld_ready) act_q.push_back(ev(1, ld_kind, ld_row, ld_col, 0));
        if (pe_valid && pe_ready) act_q.push_back(ev(2, pe_y, pe_x, pe_ci, 0));
        if (pp_valid && pp_ready) act_q.push_back(ev(4, pp_co, pp_bias_ci, 0, 0));
        if (wb_valid && wb_ready) begin
          if (wb_op) act_q.push_back(ev(5, wb_co, 0, 0, wb_gp));
          else       act_q.push_back(ev(3, wb_y, wb_x, 0, 0));
        end
      end
    end
  end

  // Expected command stream built from the requirements
  task automatic build_exp(int h, int w, int ci, int co, bit s2, bit gp);
    int nxt;
    int yo;
    int xo;
    exp_q.delete();
    exp_q.push_back(ev(1, 0, 0, 0, 0));                       // R1
    if (w < h * w) exp_q.push_back(ev(1, 1, 1, 0, 0));        // R1
    nxt = w + 1;
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        if (nxt < h * w) begin                                // R2, R3
          exp_q.push_back(ev(1, 1, nxt / w, nxt % w, 0));
          nxt++;
        end
        if (s2 && ((x % 2) != 0 || (y % 2) != 0)) continue;  // R4
        for (int c = 0; c < ci; c++) exp_q.push_back(ev(2, y, x, c, 0)); // R5
        yo = s2 ? y / 2 : y;
        xo = s2 ? x / 2 : x;
        exp_q.push_back(ev(3, yo, xo, 0, 0));                 // R6
        for (int o = 0; o < co; o++) begin                    // R7, R8
          exp_q.push_back(ev(4, o, ci, 0, 0));
          exp_q.push_back(ev(5, o, 0, 0, !gp ? 0 : ((yo == 0 && xo == 0) ? 1 : 2)));
        end
      end
    end
  endtask

  function automatic string tag_req(logic [31:0] e);
    case (e[31:28])
      4'd1: return "R2";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_layer(int h, int w, int ci, int co, bit s2, bit gp, bit poke);
    int cyc;
    int ld_n;
    int bad_odd;
    int mism;
    build_exp(h, w, ci, co, s2, gp);
    act_q.delete();
    done_cnt = 0;
    hold_errs = 0;
    @(negedge clk);
    cfg_height = DIM_W'(h); cfg_width = DIM_W'(w);
    cfg_ch_in = CH_W'(ci); cfg_ch_out = CH_W'(co);
    cfg_stride2 = s2; cfg_gpool = gp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 6) begin     // R10: start while busy, new config
        start = 1'b1; cfg_height = 8'd9; cfg_width = 8'd9; cfg_ch_in = 8'd5; cfg_stride2 = !s2;
      end else start = 1'b0;
    end
    check(cyc < 20000, "R10", "watchdog: done seen", cyc, 0);
    repeat (6) @(negedge clk);
    #2;
    check(done_cnt == 1, "R10", "done pulse count", done_cnt, 1);
    check(!busy, "R10", "busy after done", busy, 0);
    check(hold_errs == 0, "R9", "hold or one-port violations", hold_errs, 0);
    check(act_q.size() > 0 && act_q[0] == exp_q[0], "R1", "first loader command",
          act_q.size() > 0 ? int'(act_q[0]) : -1, int'(exp_q[0]));
    ld_n = 0; bad_odd = 0;
    foreach (act_q[i]) begin
      if (act_q[i][31:28] == 4'd1) ld_n++;
      if (s2 && act_q[i][31:28] == 4'd2 && (act_q[i][20] || act_q[i][12])) bad_odd++;
    end
    check(ld_n == 1 + h * w - w, "R3", "loader command count", ld_n, 1 + h * w - w);
    if (s2) check(bad_odd == 0, "R4", "processing at odd position", bad_odd, 0);
    mism = -1;
    for (int i = 0; i < exp_q.size() && i < act_q.size(); i++)
      if (mism < 0 && act_q[i] != exp_q[i]) mism = i;
    if (mism >= 0)
      check(1'b0, tag_req(exp_q[mism]), $sformatf("stream entry %0d", mism), int'(act_q[mism]), int'(exp_q[mism]));
    else
      check(act_q.size() == exp_q.size(), "R2", "stream length", act_q.size(), exp_q.size());
  endtask

  initial begin
    #(5 * 150000);
    failures++;
    $display("FAIL R10 watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    check(!busy && !done, "R10", "reset idle", {busy, done}, 0);
    check(!ld_valid && !pe_valid && !pp_valid && !wb_valid, "R9", "reset valids",
          {ld_valid, pe_valid, pp_valid, wb_valid}, 0);
    run_layer(3, 4, 2, 3, 1'b0, 1'b1, 1'b0);   // R6 R7 R8 stride 1
    run_layer(4, 5, 1, 2, 1'b1, 1'b1, 1'b0);   // R4 stride 2, odd width
    run_layer(1, 1, 1, 1, 1'b0, 1'b0, 1'b0);   // single pixel, R3 no pixel preload
    run_layer(1, 3, 2, 1, 1'b1, 1'b0, 1'b0);   // single row stride 2
    run_layer(5, 1, 1, 2, 1'b0, 1'b1, 1'b0);   // single column
    run_layer(4, 4, 3, 2, 1'b1, 1'b0, 1'b1);   // R10 start ignored while busy
    for (int k = 0; k < 6; k++)
      run_layer(1 + $urandom % 6, 1 + $urandom % 6, 1 + $urandom % 4,
                1 + $urandom % 4, 1'($urandom % 2), 1'($urandom % 2), 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule